// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the SCL waveform of an I2C master from three 32-bit timing words. It times the low and high halves of every bit, marks where in the low half the data path should change SDA and where in the high half it should sample SDA, and sequences the START, repeated START and STOP conditions. That includes the hold time with SCL high after a START and the idle gap required between a STOP and the next START. It does not shift data or decode commands. A separate data path owns SDA and acts on the strobes this block gives it.

Control is by one-cycle request pulses. A START is accepted only while the bus is idle. Bit, STOP or repeated-START requests are accepted only while the block is parked with SCL held low. When a requested sequence ends, the block gives a one-cycle done pulse. The block reads SCL back from the bus and does not count high time while SCL is still held low, so a target can stretch the clock.

Top module: `i2c_scl_timer`

## Requirements
- R1: While reset is held and right after it is released, SCL is released (`scl_o` = 1), no strobe is given, `done_o` is low and the block is idle.
- R2: The low half of a bit, STOP or repeated START lasts `tmg1_i[31:16]` + 2 clock cycles, with `scl_o` = 0.
- R3: The high half lasts `tmg0_i[31:16]` + 7 clock cycles in which `scl_i` is read high, with `scl_o` = 1.
- R4: During the high half, a cycle in which `scl_i` reads low is not counted, so clock stretching lengthens the high half one cycle for each such cycle.
- R5: `sda_chg_o` pulses in the low half at cycle index `tmg1_i[15:0]`, where the first low cycle is index 0. If that index is at or beyond the low length, no pulse is given.
- R6: `sda_smp_o` pulses only in the high half of a data bit, at counted high cycle index `tmg0_i[15:0]`, and only while `scl_i` is high. STOP and repeated START give no sample pulse, and an index at or beyond the high length gives none.
- R7: A START gives one cycle with `sda_chg_o` = 1 and SCL high. SCL then stays high for `tmg2_i[15:0]` cycles (a value of 0 acts as 1), after which SCL goes low and the block parks.
- R8: A STOP is a low half, then a high half, then one cycle with `sda_chg_o` = 1 and SCL high, after which the block is idle. The `sda_chg_o` pulse of a later START comes no earlier than `tmg2_i[31:16]` cycles after the first idle cycle.
- R9: `done_o` is a one-cycle pulse in the first cycle after a bit, START or STOP sequence has ended.
- R10: A bit or STOP request while idle, and any request during an active sequence, is ignored and leaves no pending effect.
- R11: When several requests arrive together while parked, START wins over STOP and STOP wins over bit. A START from parked makes a repeated START: a low half, a high half, then the START sequence of R7, ending parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmg0_i | input | 32 | High count [31:16], sample index [15:0] |
| tmg1_i | input | 32 | Low count [31:16], change index [15:0] |
| tmg2_i | input | 32 | Bus-free cycles [31:16], START hold cycles [15:0] |
| bit_req_i | input | 1 | Request one data bit |
| start_req_i | input | 1 | Request START or repeated START |
| stop_req_i | input | 1 | Request STOP |
| scl_i | input | 1 | SCL level read back from the bus |
| scl_o | output | 1 | 1 releases SCL, 0 drives it low |
| sda_chg_o | output | 1 | Strobe: data path updates SDA |
| sda_smp_o | output | 1 | Strobe: data path samples SDA |
| done_o | output | 1 | Sequence completed pulse |

## Verification
The bench builds the block with its default widths and overheads: 32-bit timing words, a low overhead of 2 and a high overhead of 7. It programs small counts (low 10, high 6, hold 5, bus-free 20), so that a complete bit takes about 25 cycles and every sequence, priority case and stretched high half fits in a short run. A second timing setting moves both strobe indices past the ends of their phases and sets the START hold to zero, which exercises the cases where no strobe is given and the minimum hold of one cycle.

// File: rtl/i2c_scl_tmg_pkg.sv
`timescale 1ns/1ps
package i2c_scl_tmg_pkg;
  typedef enum logic [2:0] {
    S_IDLE,   // bus free, SCL released
    S_SWAIT,  // START requested, waiting on bus-free gap
    S_SGO,    // SDA falls with SCL high
    S_LEAD,   // START hold, SCL high
    S_PARK,   // SCL held low between sequences
    S_LOW,    // low half
    S_HIGH,   // high half, counts only while SCL reads high
    S_STOPE   // SDA rises with SCL high
  } tmg_state_e;

  typedef enum logic [1:0] {
    K_BIT,
    K_STOP,
    K_RSTART
  } phase_kind_e;
endpackage

// File: rtl/i2c_tmg_fields.sv
`timescale 1ns/1ps
module i2c_tmg_fields #(
  parameter int unsigned REG_W      = 32,
  parameter int unsigned LOW_EXTRA  = 2,
  parameter int unsigned HIGH_EXTRA = 7,
  parameter int unsigned FW         = REG_W / 2,
  parameter int unsigned LW         = FW + 1
) (
  input  logic [REG_W-1:0] tmg0_i,
  input  logic [REG_W-1:0] tmg1_i,
  input  logic [REG_W-1:0] tmg2_i,
  output logic [LW-1:0]    low_len_o,
  output logic [LW-1:0]    high_len_o,
  output logic [FW-1:0]    chg_off_o,
  output logic [FW-1:0]    smp_off_o,
  output logic [FW-1:0]    lead_len_o,
  output logic [FW-1:0]    free_len_o
);
  logic [FW-1:0] lead_raw;

  assign low_len_o  = LW'(tmg1_i[REG_W-1:FW]) + LW'(LOW_EXTRA);
  assign high_len_o = LW'(tmg0_i[REG_W-1:FW]) + LW'(HIGH_EXTRA);
  assign chg_off_o  = tmg1_i[FW-1:0];
  assign smp_off_o  = tmg0_i[FW-1:0];
  assign lead_raw   = tmg2_i[FW-1:0];
  // a zero hold still spends one cycle with SCL high
  assign lead_len_o = (lead_raw == '0) ? FW'(1) : lead_raw;
  assign free_len_o = tmg2_i[REG_W-1:FW];
endmodule

// File: rtl/i2c_tmg_phase_ctr.sv
`timescale 1ns/1ps
module i2c_tmg_phase_ctr #(
  parameter int unsigned W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_o <= '0;
    else if (clr_i) idx_o <= '0;
    else if (en_i)  idx_o <= idx_o + W'(1);
  end
endmodule

// File: rtl/i2c_tmg_free_ctr.sv
`timescale 1ns/1ps
module i2c_tmg_free_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         busy_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/i2c_scl_timer.sv
`timescale 1ns/1ps
module i2c_scl_timer
  import i2c_scl_tmg_pkg::*;
#(
  parameter int unsigned REG_W      = 32,
  parameter int unsigned LOW_EXTRA  = 2,
  parameter int unsigned HIGH_EXTRA = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] tmg0_i,
  input  logic [REG_W-1:0] tmg1_i,
  input  logic [REG_W-1:0] tmg2_i,
  input  logic             bit_req_i,
  input  logic             start_req_i,
  input  logic             stop_req_i,
  input  logic             scl_i,
  output logic             scl_o,
  output logic             sda_chg_o,
  output logic             sda_smp_o,
  output logic             done_o
);
  localparam int unsigned FW = REG_W / 2;
  localparam int unsigned LW = FW + 1;

  tmg_state_e  state_q, state_d;
  phase_kind_e kind_q, kind_d;
  logic        done_q, done_d;
  logic        free_load, free_busy;
  logic        idx_clr, idx_en;
  logic [LW-1:0] phase_idx;

  logic [LW-1:0] low_len, high_len;
  logic [FW-1:0] chg_off, smp_off, lead_len, free_len;

  i2c_tmg_fields #(
    .REG_W(REG_W), .LOW_EXTRA(LOW_EXTRA), .HIGH_EXTRA(HIGH_EXTRA), .FW(FW), .LW(LW)
  ) u_fields (
    .tmg0_i    (tmg0_i),
    .tmg1_i    (tmg1_i),
    .tmg2_i    (tmg2_i),
    .low_len_o (low_len),
    .high_len_o(high_len),
    .chg_off_o (chg_off),
    .smp_off_o (smp_off),
    .lead_len_o(lead_len),
    .free_len_o(free_len)
  );

  i2c_tmg_phase_ctr #(.W(LW)) u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (idx_clr),
    .en_i  (idx_en),
    .idx_o (phase_idx)
  );

  i2c_tmg_free_ctr #(.W(FW)) u_free (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(free_load),
    .val_i (free_len),
    .busy_o(free_busy)
  );

  logic low_last, high_last, lead_last;
  assign low_last  = (phase_idx == low_len - LW'(1));
  assign high_last = scl_i && (phase_idx == high_len - LW'(1));
  assign lead_last = (phase_idx == LW'(lead_len) - LW'(1));

  always_comb begin
    state_d   = state_q;
    kind_d    = kind_q;
    done_d    = 1'b0;
    free_load = 1'b0;
    unique case (state_q)
      S_IDLE:  if (start_req_i) state_d = S_SWAIT;
      S_SWAIT: if (!free_busy) state_d = S_SGO;
      S_SGO:   state_d = S_LEAD;
      S_LEAD: begin
        if (lead_last) begin
          state_d = S_PARK;
          done_d  = 1'b1;
        end
      end
      S_PARK: begin
        // priority: start, stop, bit
        if (start_req_i) begin
          state_d = S_LOW;
          kind_d  = K_RSTART;
        end else if (stop_req_i) begin
          state_d = S_LOW;
          kind_d  = K_STOP;
        end else if (bit_req_i) begin
          state_d = S_LOW;
          kind_d  = K_BIT;
        end
      end
      S_LOW:   if (low_last) state_d = S_HIGH;
      S_HIGH: begin
        if (high_last) begin
          unique case (kind_q)
            K_STOP:   state_d = S_STOPE;
            K_RSTART: state_d = S_SGO;
            default: begin
              state_d = S_PARK;
              done_d  = 1'b1;
            end
          endcase
        end
      end
      S_STOPE: begin
        state_d   = S_IDLE;
        done_d    = 1'b1;
        free_load = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign idx_clr = (state_d != state_q);
  assign idx_en  = (state_q == S_LEAD) || (state_q == S_LOW) ||
                   ((state_q == S_HIGH) && scl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_BIT;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      done_q  <= done_d;
    end
  end

  assign scl_o     = !((state_q == S_PARK) || (state_q == S_LOW));
  assign sda_chg_o = ((state_q == S_LOW) && (phase_idx == LW'(chg_off))) ||
                     (state_q == S_SGO) || (state_q == S_STOPE);
  assign sda_smp_o = (state_q == S_HIGH) && (kind_q == K_BIT) && scl_i &&
                     (phase_idx == LW'(smp_off));
  assign done_o    = done_q;
endmodule

// File: rtl/i2c_scl_timer_chk.sv
`timescale 1ns/1ps
module i2c_scl_timer_chk
  import i2c_scl_tmg_pkg::*;
#(
  parameter int unsigned LW = 17
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          scl_o,
  input logic          sda_chg_o,
  input logic          sda_smp_o,
  input logic          done_o,
  input tmg_state_e    state_q,
  input logic [LW-1:0] phase_idx,
  input logic          free_busy
);
  // R4: a low read-back freezes the high-phase count
  a_r4_stretch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HIGH && !scl_i) |=> $stable(phase_idx));

  // R5: change strobes never last two cycles
  a_r5_chg_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_chg_o |=> !sda_chg_o);

  // R6: sampling only with SCL released and read high
  a_r6_smp_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_smp_o |-> (scl_o && scl_i));

  // R8: no START edge while the bus-free gap runs
  a_r8_free_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_SWAIT && free_busy) |=> (state_q != S_SGO));

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind i2c_scl_timer i2c_scl_timer_chk #(.LW(LW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .scl_o    (scl_o),
  .sda_chg_o(sda_chg_o),
  .sda_smp_o(sda_smp_o),
  .done_o   (done_o),
  .state_q  (state_q),
  .phase_idx(phase_idx),
  .free_busy(free_busy)
);

// File: tb/tb_i2c_scl_timer.sv
`timescale 1ns/1ps
module tb_i2c_scl_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tmg0, tmg1, tmg2;
  logic        bit_req = 1'b0, start_req = 1'b0, stop_req = 1'b0;
  logic        hold = 1'b0;
  logic        scl_bus;
  logic        scl_o, sda_chg_o, sda_smp_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign scl_bus = scl_o & ~hold;

  i2c_scl_timer dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tmg0_i     (tmg0),
    .tmg1_i     (tmg1),
    .tmg2_i     (tmg2),
    .bit_req_i  (bit_req),
    .start_req_i(start_req),
    .stop_req_i (stop_req),
    .scl_i      (scl_bus),
    .scl_o      (scl_o),
    .sda_chg_o  (sda_chg_o),
    .sda_smp_o  (sda_smp_o),
    .done_o     (done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  localparam int P_IDLE = 0, P_SWAIT = 1, P_SGO = 2, P_LEAD = 3,
                 P_PARK = 4, P_LOW = 5, P_HIGH = 6, P_STOPE = 7;
  int m_ph, m_kind, m_t, m_free;
  bit m_done;

  function automatic bit m_scl();
    return !(m_ph == P_PARK || m_ph == P_LOW);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = P_IDLE; m_kind = 0; m_t = 0; m_free = 0; m_done = 0;
    end else begin
      int ll, hl, ld, np, nk;
      bit nd, bus, busy;
      ll = int'(tmg1[31:16]) + 2;
      hl = int'(tmg0[31:16]) + 7;
      ld = (tmg2[15:0] == 16'd0) ? 1 : int'(tmg2[15:0]);
      bus = m_scl() && !hold;
      busy = (m_free > 0);
      np = m_ph; nk = m_kind; nd = 0;
      case (m_ph)
        P_IDLE:  if (start_req) np = P_SWAIT;
        P_SWAIT: if (!busy) np = P_SGO;
        P_SGO:   np = P_LEAD;
        P_LEAD:  if (m_t + 1 >= ld) begin np = P_PARK; nd = 1; end
        P_PARK: begin
          if (start_req)      begin np = P_LOW; nk = 2; end
          else if (stop_req)  begin np = P_LOW; nk = 1; end
          else if (bit_req)   begin np = P_LOW; nk = 0; end
        end
        P_LOW:   if (m_t + 1 >= ll) np = P_HIGH;
        P_HIGH: begin
          if (bus && m_t + 1 >= hl) begin
            if (m_kind == 1) np = P_STOPE;
            else if (m_kind == 2) np = P_SGO;
            else begin np = P_PARK; nd = 1; end
          end
        end
        P_STOPE: begin np = P_IDLE; nd = 1; end
        default: np = P_IDLE;
      endcase
      if (m_ph == P_STOPE) m_free = int'(tmg2[31:16]);
      else if (busy) m_free = m_free - 1;
      if (np != m_ph) m_t = 0;
      else if (m_ph == P_LEAD || m_ph == P_LOW || (m_ph == P_HIGH && bus)) m_t = m_t + 1;
      m_ph = np; m_kind = nk; m_done = nd;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_scl, e_chg, e_smp, bus;
      e_scl = m_scl();
      bus = e_scl && !hold;
      e_chg = (m_ph == P_LOW && m_t == int'(tmg1[15:0])) || m_ph == P_SGO || m_ph == P_STOPE;
      e_smp = (m_ph == P_HIGH) && (m_kind == 0) && bus && (m_t == int'(tmg0[15:0]));
      chk(scl_o == e_scl, "R2/R3 scl", scl_o, e_scl);
      chk(sda_chg_o == e_chg, "R5 chg", sda_chg_o, e_chg);
      chk(sda_smp_o == e_smp, "R6 smp", sda_smp_o, e_smp);
      chk(done_o == m_done, "R9 done", done_o, m_done);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulse(input bit b, input bit s, input bit p);
    @(posedge clk); #1;
    bit_req = b; start_req = s; stop_req = p;
    @(posedge clk); #1;
    bit_req = 0; start_req = 0; stop_req = 0;
  endtask

  task automatic run_seq(input int rel_at, output int lo, output int hi,
                         output int nchg, output int nsmp, output int end_scl);
    bit seen;
    lo = 0; hi = 0; nchg = 0; nsmp = 0; end_scl = -1; seen = 0;
    for (int k = 1; k < 4000; k++) begin
      @(negedge clk);
      if (done_o) begin
        end_scl = scl_o;
        seen = 1;
        break;
      end
      if (scl_o) hi++; else lo++;
      if (sda_chg_o) nchg++;
      if (sda_smp_o) nsmp++;
      if (k == rel_at) begin
        @(posedge clk); #1 hold = 0;
      end
    end
    if (!seen) chk(0, "R9 done never seen", 0, 1);
  endtask

  int lo, hi, nc, ns, es;

  initial begin
    tmg0 = {16'd6, 16'd2};
    tmg1 = {16'd10, 16'd4};
    tmg2 = {16'd20, 16'd5};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk(scl_o == 1'b1, "R1 scl released in reset", scl_o, 1);
    chk(!sda_chg_o && !sda_smp_o && !done_o, "R1 quiet in reset", sda_chg_o | sda_smp_o | done_o, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(scl_o == 1'b1 && !done_o, "R1 idle after reset", scl_o, 1);

    // R10: bit and stop ignored while idle
    pulse(1, 0, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(scl_o == 1'b1 && !done_o && !sda_chg_o, "R10 idle ignores bit/stop", scl_o, 1);
    end

    // R7: START from idle (one wait cycle, strobe cycle, hold 5)
    pulse(0, 1, 0);
    run_seq(0, lo, hi, nc, ns, es);
    chk(hi == 7 && lo == 0, "R7 start high cycles", hi, 7);
    chk(nc == 1, "R7 start change strobe", nc, 1);
    chk(es == 0, "R7 start parks low", es, 0);

    // R2 R3 R5 R6 R9: plain bit
    pulse(1, 0, 0);
    run_seq(0, lo, hi, nc, ns, es);
    chk(lo == 12, "R2 low length", lo, 12);
    chk(hi == 13, "R3 high length", hi, 13);
    chk(nc == 1, "R5 one change strobe", nc, 1);
    chk(ns == 1, "R6 one sample strobe", ns, 1);
    @(negedge clk);
    chk(!done_o, "R9 done one cycle", done_o, 0);

    // R4: stretched high half (3 stretched cycles)
    hold = 1'b1;
    pulse(1, 0, 0);
    run_seq(15, lo, hi, nc, ns, es);
    chk(lo == 12, "R4 low unchanged", lo, 12);
    chk(hi == 16, "R4 stretched high", hi, 16);
    chk(ns == 1, "R4 sample after stretch", ns, 1);

    // R11: all three together -> repeated start
    pulse(1, 1, 1);
    run_seq(0, lo, hi, nc, ns, es);
    chk(lo == 12 && hi == 19, "R11 repeated start shape", hi, 19);
    chk(nc == 2 && ns == 0, "R11 repeated start strobes", nc, 2);
    chk(es == 0, "R11 repeated start parks", es, 0);

    // R10: stop during a bit is ignored
    fork
      begin
        repeat (3) @(posedge clk);
        #1 stop_req = 1;
        @(posedge clk); #1 stop_req = 0;
      end
    join_none
    pulse(1, 0, 0);
    run_seq(0, lo, hi, nc, ns, es);
    chk(lo == 12 && hi == 13 && es == 0, "R10 request in phase ignored", hi, 13);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(scl_o == 1'b0 && !done_o, "R10 no pending request", scl_o, 0);
    end

    // R11 + R8: stop beats bit; then bus-free gap
    pulse(1, 0, 1);
    run_seq(0, lo, hi, nc, ns, es);
    chk(lo == 12 && hi == 14, "R8 stop shape", hi, 14);
    chk(nc == 2 && ns == 0, "R8 stop strobes", nc, 2);
    chk(es == 1, "R11 stop wins over bit", es, 1);
    pulse(0, 1, 0);
    begin
      int k_at;
      k_at = -1;
      for (int k = 1; k < 200; k++) begin
        @(negedge clk);
        if (sda_chg_o) begin k_at = k; break; end
      end
      chk(k_at == 20, "R8 bus-free gap before START", k_at, 20);
    end
    run_seq(0, lo, hi, nc, ns, es);
    chk(hi == 5 && es == 0, "R7 lead-in hold", hi, 5);

    // config B: offsets beyond phases, zero hold, no gap
    @(posedge clk); #1;
    tmg0 = {16'd0, 16'd9};
    tmg1 = {16'd3, 16'd20};
    tmg2 = {16'd0, 16'd0};
    pulse(1, 0, 0);
    run_seq(0, lo, hi, nc, ns, es);
    chk(lo == 5 && hi == 7, "R2 short bit", lo, 5);
    chk(nc == 0, "R5 change index out of range", nc, 0);
    chk(ns == 0, "R6 sample index out of range", ns, 0);
    pulse(0, 0, 1);
    run_seq(0, lo, hi, nc, ns, es);
    chk(es == 1 && hi == 8, "R8 short stop", hi, 8);
    pulse(0, 1, 0);
    run_seq(0, lo, hi, nc, ns, es);
    chk(hi == 3 && nc == 1 && es == 0, "R7 zero hold acts as one", hi, 3);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule